// File: doc/BRIEF.md
# Six-Digit BCD Up/Down Counter with Compare Flags

The block holds a six-digit binary-coded-decimal count that steps by one on each rising edge of a count strobe. The step goes up or down, selected by a direction input, and an inhibit input blocks it. Next to the count sits a six-digit compare register. Both the count and the compare register are written one digit per clock from an external loader, which presents a digit index and a 4-bit digit value.

Three registered flags are reported:
- **Zero** marks a count of all zeros.
- **Equal** marks a count that matches the compare register.
- **Carry** marks a wrap past the end of the range in either direction.

An active-high clear zeroes the count asynchronously and leaves the compare register untouched.

An elaboration-time mask lets chosen digits wrap at 5 instead of 9, so the same logic can count hours, minutes and seconds. For example, mask `6'b001010` gives a top count of 99:59:59. Mask `6'b101000` gives 59:59:99.

Top module: `bcd_updown_compare`

## Requirements
- R1: With `up_i` high, a clock where `count_i` is high after being low one clock earlier, with `inhibit_i` and `ld_cnt_i` low, adds one to the count. The result is visible on `digits_o` after that clock edge. Digit k sits in bits [4k+3:4k], and digit 0 is least significant.
- R2: With `up_i` low, the same strobe edge subtracts one from the count.
- R3: While `inhibit_i` is high, a strobe edge leaves `digits_o` unchanged.
- R4: A high level on `clear_i` zeroes `digits_o` at once, without waiting for a clock. The count stays at zero until two clock edges after `clear_i` falls. The compare register keeps its value through a clear.
- R5: `carry_o` rises on the advancing edge that wraps the count. Counting up, the wrap is to all zeros. Counting down, the wrap is to the top value, which is 9 in each decimal digit and 5 in each mask digit. `carry_o` falls on the first clock at which `count_i` is sampled low.
- R6: After an advancing edge, `zero_o` is high exactly when the new count is all zeros. `zero_o` holds that value until the next advancing edge. It is forced low on the clock after any cycle with `ld_cnt_i` high.
- R7: After an advancing edge, `equal_o` is high exactly when the new count equals the compare register. `equal_o` is forced low after any `ld_cnt_i` or `ld_reg_i` cycle. It can be set again only by an advancing edge that comes after a `blank_i` pulse seen with both load inputs low.
- R8: A digit whose bit in `MOD6_MASK` is set runs 0 to 5. It wraps 5→0 when counting up and 0→5 when counting down. Every other digit runs 0 to 9. The step into the next digit is a lookahead over all lower digits.
- R9: A clock with `ld_cnt_i` high writes `ld_data_i` into count digit `ld_sel_i`. If a strobe edge arrives in the same clock, the load takes priority and the strobe edge is dropped. `ld_reg_i` writes the compare register digit in the same way.
- R10: While `rst_ni` is low, `digits_o` reads zero and all three flags read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 1 | Count strobe; its rising edge advances the count |
| up_i | input | 1 | 1 = count up, 0 = count down |
| inhibit_i | input | 1 | Blocks the count strobe |
| clear_i | input | 1 | Asynchronous count clear, active high |
| ld_cnt_i | input | 1 | Write one count digit |
| ld_reg_i | input | 1 | Write one compare register digit |
| ld_sel_i | input | 3 | Digit index for a load |
| ld_data_i | input | 4 | BCD digit value for a load |
| blank_i | input | 1 | Display blanking pulse; ends the suppression of the equal flag |
| digits_o | output | 24 | Count digits, digit 0 in the low nibble |
| zero_o | output | 1 | Count-is-zero flag |
| equal_o | output | 1 | Count-equals-register flag |
| carry_o | output | 1 | Wrap flag |

## Verification
The assertions assume that all inputs except `clear_i` are synchronous to `clk_i`. They also assume that every loaded digit is legal for its position (no more than 5 in a mask digit, no more than 9 elsewhere), since the digit-range property would otherwise fail. The bench drives every input on the falling clock edge and builds each loaded value by splitting a mixed-radix integer into digits, so an illegal digit is never loaded. The expected count is an integer held modulo 360000. Its digits, flags and wrap points are derived from that integer by arithmetic.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  function automatic digit_t digit_top(input bit mod6);
    return mod6 ? digit_t'(5) : digit_t'(9);
  endfunction
endpackage

// File: rtl/bcd_digit_step.sv
module bcd_digit_step
  import bcd_cnt_pkg::*;
#(
  parameter bit MOD6 = 1'b0
) (
  input  digit_t d_i,
  input  logic   up_i,
  input  logic   en_i,
  output digit_t d_o,
  output logic   term_o
);
  localparam digit_t TOP = digit_top(MOD6);

  // terminal digit: the one that passes a step on to the next decade
  assign term_o = up_i ? (d_i == TOP) : (d_i == '0);

  always_comb begin
    if (!en_i)     d_o = d_i;
    else if (up_i) d_o = term_o ? '0  : d_i + digit_t'(1);
    else           d_o = term_o ? TOP : d_i - digit_t'(1);
  end
endmodule

// File: rtl/bcd_clear_sync.sv
module bcd_clear_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic rst_no
);
  logic             arst_n;
  logic [STAGES-1:0] sync_q;

  assign arst_n = rst_ni & ~clear_i;

  // assert immediately, release on a clock
  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/bcd_updown_compare.sv
module bcd_updown_compare
  import bcd_cnt_pkg::*;
#(
  parameter int           NDIG      = 6,
  parameter logic [5:0]   MOD6_MASK = 6'b000000,
  parameter int           SYNC_STG  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    count_i,
  input  logic                    up_i,
  input  logic                    inhibit_i,
  input  logic                    clear_i,
  input  logic                    ld_cnt_i,
  input  logic                    ld_reg_i,
  input  logic [$clog2(NDIG)-1:0] ld_sel_i,
  input  logic [DIGIT_W-1:0]      ld_data_i,
  input  logic                    blank_i,
  output logic [NDIG*DIGIT_W-1:0] digits_o,
  output logic                    zero_o,
  output logic                    equal_o,
  output logic                    carry_o
);
  localparam int SELW = $clog2(NDIG);

  logic                     cnt_rst_n;
  logic                     count_q, supp_q;
  logic                     zero_q, eq_q, carry_q;
  logic                     edge_w, adv_w, wrap_w, sel_ok_w;
  logic [NDIG-1:0]          term_w, en_w;
  digit_t [NDIG-1:0]        cnt_q, reg_q, nxt_w;

  bcd_clear_sync #(.STAGES(SYNC_STG)) u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .rst_no (cnt_rst_n)
  );

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    if (i == 0) begin : g_lsd
      assign en_w[i] = 1'b1;
    end else begin : g_up
      assign en_w[i] = &term_w[i-1:0];  // lookahead over all lower digits
    end
    bcd_digit_step #(.MOD6(MOD6_MASK[i])) u_step (
      .d_i   (cnt_q[i]),
      .up_i  (up_i),
      .en_i  (en_w[i]),
      .d_o   (nxt_w[i]),
      .term_o(term_w[i])
    );
    p_digit_range_r8: assert property (@(posedge clk_i) disable iff (!cnt_rst_n)
      cnt_q[i] <= digit_top(MOD6_MASK[i]));
  end

  assign wrap_w   = &term_w;
  assign edge_w   = count_i & ~count_q;
  assign adv_w    = edge_w & ~inhibit_i & ~ld_cnt_i;
  assign sel_ok_w = int'(ld_sel_i) < NDIG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= 1'b0;
      supp_q  <= 1'b0;
      reg_q   <= '0;
    end else begin
      count_q <= count_i;
      if (ld_cnt_i || ld_reg_i) supp_q <= 1'b1;
      else if (blank_i)         supp_q <= 1'b0;
      if (ld_reg_i && sel_ok_w) reg_q[ld_sel_i] <= ld_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge cnt_rst_n) begin
    if (!cnt_rst_n) begin
      cnt_q   <= '0;
      zero_q  <= 1'b0;
      eq_q    <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (ld_cnt_i && sel_ok_w) cnt_q[ld_sel_i] <= ld_data_i;
      else if (adv_w)           cnt_q <= nxt_w;

      if (adv_w)                     carry_q <= wrap_w;
      else if (count_q && !count_i)  carry_q <= 1'b0;

      if (ld_cnt_i)   zero_q <= 1'b0;
      else if (adv_w) zero_q <= (nxt_w == '0);

      if (ld_cnt_i || ld_reg_i || supp_q) eq_q <= 1'b0;
      else if (adv_w)                     eq_q <= (nxt_w == reg_q);
    end
  end

  assign digits_o = cnt_q;
  assign zero_o   = zero_q;
  assign equal_o  = eq_q;
  assign carry_o  = carry_q;

  p_inhibit_hold_r3: assert property (@(posedge clk_i) disable iff (!cnt_rst_n)
    (inhibit_i && !ld_cnt_i) |=> $stable(digits_o));
  p_carry_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_i |=> !carry_o);
  p_zero_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_cnt_i |=> !zero_o);
  p_equal_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cnt_i || ld_reg_i) |=> !equal_o);
  p_load_write_r9: assert property (@(posedge clk_i) disable iff (!cnt_rst_n)
    (ld_cnt_i && sel_ok_w) |=> cnt_q[$past(ld_sel_i)] == $past(ld_data_i));
endmodule

// File: tb/tb_bcd_updown_compare.sv
module tb_bcd_updown_compare;
  localparam logic [5:0] MASK  = 6'b001010;
  localparam int         TOTAL = 360000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        count_i = 0, up_i = 1, inhibit_i = 0, clear_i = 0;
  logic        ld_cnt_i = 0, ld_reg_i = 0, blank_i = 0;
  logic [2:0]  ld_sel_i = '0;
  logic [3:0]  ld_data_i = '0;
  logic [23:0] digits_o;
  logic        zero_o, equal_o, carry_o;

  int checks = 0, errors = 0;
  int m = 0, regm = 0;
  bit eq_en = 0;

  always #10 clk_i = ~clk_i;

  bcd_updown_compare #(.NDIG(6), .MOD6_MASK(MASK)) dut (
    .clk_i, .rst_ni, .count_i, .up_i, .inhibit_i, .clear_i,
    .ld_cnt_i, .ld_reg_i, .ld_sel_i, .ld_data_i, .blank_i,
    .digits_o, .zero_o, .equal_o, .carry_o
  );

  function automatic logic [23:0] enc(input int v);
    logic [23:0] r = '0;
    int x = v;
    for (int i = 0; i < 6; i++) begin
      int rad = MASK[i] ? 6 : 10;
      r[i*4 +: 4] = 4'(x % rad);
      x = x / rad;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_value(input bit to_reg, input int v, input bit do_blank);
    logic [23:0] d = enc(v);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      ld_cnt_i = !to_reg; ld_reg_i = to_reg;
      ld_sel_i = 3'(i);   ld_data_i = d[i*4 +: 4];
    end
    @(negedge clk_i);
    ld_cnt_i = 0; ld_reg_i = 0;
    eq_en = 0;
    if (to_reg) regm = v; else m = v;
    if (do_blank) begin
      blank_i = 1; @(negedge clk_i); blank_i = 0; eq_en = 1;
    end
  endtask

  task automatic step(input bit up, input string req);
    bit cexp;
    @(negedge clk_i);
    up_i = up; count_i = 1;
    @(negedge clk_i);
    if (up) begin m = (m + 1) % TOTAL; cexp = (m == 0); end
    else    begin m = (m + TOTAL - 1) % TOTAL; cexp = (m == TOTAL - 1); end
    check(req, 32'(digits_o), 32'(enc(m)));
    check("R5 carry", 32'(carry_o), 32'(cexp));
    check("R6 zero", 32'(zero_o), 32'(m == 0));
    check("R7 equal", 32'(equal_o), 32'(eq_en && m == regm));
    count_i = 0;
    @(negedge clk_i);
    check("R5 carry fall", 32'(carry_o), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 digits", 32'(digits_o), 32'd0);
    check("R10 flags", {29'd0, zero_o, equal_o, carry_o}, 32'd0);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);

    // R1 R8 up sweep across minute and hour rollovers, equal hit at 3605
    load_value(1, 3605, 0);
    load_value(0, 3590, 1);
    for (int k = 0; k < 400; k++) step(1, "R1 R8 up");

    // R5 up wrap from 99:59:50
    load_value(0, TOTAL - 10, 1);
    for (int k = 0; k < 20; k++) step(1, "R1 R5 wrap up");

    // R2 R8 down sweep through zero
    load_value(0, 130, 1);
    for (int k = 0; k < 160; k++) step(0, "R2 R8 down");

    // R6 zero forced low by a counter load
    load_value(0, 1, 1);
    step(0, "R2 to zero");
    @(negedge clk_i); ld_cnt_i = 1; ld_sel_i = 3'd5; ld_data_i = 4'd0;
    @(negedge clk_i); ld_cnt_i = 0;
    check("R6 zero forced low", 32'(zero_o), 32'd0);

    // R7 suppression held until blank
    load_value(1, 2, 0);
    step(1, "R1"); step(1, "R7 suppressed");
    blank_i = 1; @(negedge clk_i); blank_i = 0; eq_en = 1;
    step(0, "R2"); step(1, "R7 equal after blank");

    // R3 inhibit
    @(negedge clk_i); inhibit_i = 1; count_i = 1;
    @(negedge clk_i); count_i = 0;
    @(negedge clk_i);
    check("R3 inhibit", 32'(digits_o), 32'(enc(m)));
    inhibit_i = 0;

    // R9 load wins over a simultaneous strobe edge
    @(negedge clk_i); up_i = 1; count_i = 1; ld_cnt_i = 1; ld_sel_i = 3'd0; ld_data_i = 4'd7;
    @(negedge clk_i); count_i = 0; ld_cnt_i = 0;
    m = m - (m % 10) + 7;
    check("R9 load wins", 32'(digits_o), 32'(enc(m)));
    load_value(0, 42317, 1);
    check("R9 full load", 32'(digits_o), 32'(enc(42317)));

    // R4 asynchronous clear keeps the compare register
    load_value(1, 1, 1);
    @(negedge clk_i); #3 clear_i = 1; #2;
    check("R4 async clear", 32'(digits_o), 32'd0);
    @(negedge clk_i); clear_i = 0; m = 0;
    @(negedge clk_i); @(negedge clk_i);
    check("R4 held zero", 32'(digits_o), 32'd0);
    step(1, "R4 count after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule